// File: doc/BRIEF.md
# Sleep-Time Interrupt Recorder and Replayer

This block sits between a set of external interrupt lines and a parent interrupt controller that may be powered down during sleep. Each line has its own polarity and sensitivity setting, and together they give four line types: rising edge, falling edge, level high and level low. Whenever a line's qualifying event occurs, the block sets a sticky status bit for that line. This happens whether or not the block is enabled, so no event is lost while the parent is asleep.

In normal operation the block passes each unmasked line to the parent. Each line is converted to an active-high signal according to its polarity. Before sleep, software sets the enable bit, which silences the parent-side outputs. It can also choose edge-only recording, so that level lines do not fill the status with events that are still pending anyway. After wake-up, a flush command walks through the lines in order. For each recorded, unmasked line it produces a single one-cycle pulse to the parent and then clears that line's status bit.

Configuration uses a simple 32-bit register bus with combinational read data. Every per-line register packs 32 lines into each word.

Top module: `irq_sleep_recorder`

## Requirements
- R1: Line n is held in word n/32 at bit n%32 of every per-line register, and the byte address of that word is the register base plus 4*(n/32). Register bases: status 0x000, acknowledge 0x040, mask-set 0x0C0, mask-clear 0x100, sensitivity-set 0x180, sensitivity-clear 0x1C0, polarity-set 0x240, polarity-clear 0x280, control 0x300.
- R2: Mask, sensitivity and polarity are changed only through write-one-to-act set and clear addresses. A 1 sets or clears the stored bit and a 0 leaves it alone. Reading a set address returns the stored bits. Reading a clear address or the acknowledge address returns 0.
- R3: The line type is decoded from polarity and sensitivity. With sensitivity 0, polarity 1 records a rising edge and polarity 0 records a falling edge. With sensitivity 1, polarity 1 records every cycle the line is high and polarity 0 records every cycle it is low. A recorded event appears in status by the third rising clock edge after the input change.
- R4: Events are recorded while the enable bit is 1 as well as while it is 0.
- R5: Writing 1 to an acknowledge bit clears that line's status bit. If an event occurs on the same line in the same cycle, the bit stays set. Status bits that are not acknowledged stay set.
- R6: While edge-only mode is on, level-type lines record nothing, and edge-type lines still record.
- R7: In the control word, bit 0 is enable, bit 1 is edge-only and bit 2 is flush. Flush reads back as 0. Control, status, mask, sensitivity and polarity all reset to 0.
- R8: When no replay is running and enable is 0, irqOut[n] is 1 exactly when line n is unmasked and its synchronised input equals its polarity bit. When enable is 1 and no replay is running, irqOut is all zero.
- R9: A write with the flush bit set starts a scan in the next cycle. The scan visits lines 0 to N-1 in ascending order, one per cycle. In the cycle for line k, irqOut is a single pulse on bit k if line k is recorded and unmasked, and is zero otherwise. That line's status bit is then cleared. Pass-through is suspended for the whole scan, and a flush request made during a scan is ignored.
- R10: A masked line never drives irqOut. Its status bit survives a replay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 12 | Register byte address |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data, combinational on busAddr |
| irqIn | input | NUM_LINES | External interrupt lines (asynchronous) |
| irqOut | output | NUM_LINES | Active-high interrupts to the parent controller |

## Verification
The bench builds the block with NUM_LINES = 36. This gives a full first word plus a partial second word, so the word and bit split of the address map and the zero upper bits of the last word can be checked for every single line. Lines are assigned the four types in rotation, so the type decode, the sticky status and the acknowledge-versus-event priority can each be predicted by simple set arithmetic. Thirty-six lines also keep a full replay scan short enough to check cycle by cycle, both with masked lines and with level lines that re-record during the scan.

// File: rtl/irq_rec_pkg.sv
package irq_rec_pkg;

  localparam int MAX_LINES  = 512;
  localparam int LINE_IDX_W = 9;
  localparam int WORD_IDX_W = 4;
  localparam int BUS_ADDR_W = 12;
  localparam int BUS_DATA_W = 32;

  // Region select is busAddr[11:6]; each region spans sixteen words.
  localparam logic [5:0] RGN_STATUS   = 6'h00;
  localparam logic [5:0] RGN_ACK      = 6'h01;
  localparam logic [5:0] RGN_MASK_SET = 6'h03;
  localparam logic [5:0] RGN_MASK_CLR = 6'h04;
  localparam logic [5:0] RGN_SENS_SET = 6'h06;
  localparam logic [5:0] RGN_SENS_CLR = 6'h07;
  localparam logic [5:0] RGN_POL_SET  = 6'h09;
  localparam logic [5:0] RGN_POL_CLR  = 6'h0A;
  localparam logic [5:0] RGN_CTRL     = 6'h0C;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_EDGE_BIT  = 1;
  localparam int CTRL_FLUSH_BIT = 2;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_ACK,
    OP_MASK_SET,
    OP_MASK_CLR,
    OP_SENS_SET,
    OP_SENS_CLR,
    OP_POL_SET,
    OP_POL_CLR
  } lineOp_e;

  typedef struct packed {
    lineOp_e                 op;
    logic [WORD_IDX_W-1:0]   word;
    logic [BUS_DATA_W-1:0]   bits;
    logic                    replayBusy;
    logic [LINE_IDX_W-1:0]   replayIdx;
    logic                    passEn;
    logic                    edgeOnly;
  } dpStrobe_t;

endpackage

// File: rtl/irq_rec_ctrl.sv
module irq_rec_ctrl
  import irq_rec_pkg::*;
#(
  parameter int NUM_LINES = 48
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [BUS_ADDR_W-1:0] addr,
  input  logic [BUS_DATA_W-1:0] wrData,
  input  logic [NUM_LINES-1:0]  status,
  input  logic [NUM_LINES-1:0]  mask,
  input  logic [NUM_LINES-1:0]  sens,
  input  logic [NUM_LINES-1:0]  pol,
  output logic [BUS_DATA_W-1:0] rdData,
  output dpStrobe_t             strobe
);

  localparam int NUM_WORDS = (NUM_LINES + 31) / 32;
  localparam int PAD_W     = MAX_LINES;

  logic [5:0]            region;
  logic [WORD_IDX_W-1:0] word;
  logic                  wordOk;
  logic [1:0]            unusedAddrLo;

  assign region       = addr[11:6];
  assign word         = addr[5:2];
  assign unusedAddrLo = addr[1:0];
  assign wordOk       = int'(word) < NUM_WORDS;

  // Control register and replay scanner
  logic                  enableQ;
  logic                  edgeOnlyQ;
  logic                  busyQ;
  logic [LINE_IDX_W-1:0] ptrQ;
  logic                  ctrlWr;
  logic                  flushStart;
  logic                  lastLine;

  assign ctrlWr     = wrEn && (region == RGN_CTRL) && (word == '0);
  assign flushStart = ctrlWr && wrData[CTRL_FLUSH_BIT] && !busyQ;
  assign lastLine   = ptrQ == LINE_IDX_W'(NUM_LINES - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ   <= 1'b0;
      edgeOnlyQ <= 1'b0;
      busyQ     <= 1'b0;
      ptrQ      <= '0;
    end else begin
      if (ctrlWr) begin
        enableQ   <= wrData[CTRL_EN_BIT];
        edgeOnlyQ <= wrData[CTRL_EDGE_BIT];
      end
      if (flushStart) begin
        busyQ <= 1'b1;
        ptrQ  <= '0;
      end else if (busyQ) begin
        if (lastLine) begin
          busyQ <= 1'b0;
        end else begin
          ptrQ <= ptrQ + 1'b1;
        end
      end
    end
  end

  // Write decode into per-line operation strobes
  lineOp_e opSel;

  always_comb begin
    opSel = OP_NONE;
    if (wrEn && wordOk) begin
      case (region)
        RGN_ACK:      opSel = OP_ACK;
        RGN_MASK_SET: opSel = OP_MASK_SET;
        RGN_MASK_CLR: opSel = OP_MASK_CLR;
        RGN_SENS_SET: opSel = OP_SENS_SET;
        RGN_SENS_CLR: opSel = OP_SENS_CLR;
        RGN_POL_SET:  opSel = OP_POL_SET;
        RGN_POL_CLR:  opSel = OP_POL_CLR;
        default:      opSel = OP_NONE;
      endcase
    end
  end

  assign strobe.op         = opSel;
  assign strobe.word       = word;
  assign strobe.bits       = wrData;
  assign strobe.replayBusy = busyQ;
  assign strobe.replayIdx  = ptrQ;
  assign strobe.passEn     = !enableQ;
  assign strobe.edgeOnly   = edgeOnlyQ;

  // Read mux: vectors are padded to the full map so any word index is legal
  logic [PAD_W-1:0] padStatus;
  logic [PAD_W-1:0] padMask;
  logic [PAD_W-1:0] padSens;
  logic [PAD_W-1:0] padPol;
  logic [8:0]       bitBase;

  assign padStatus = PAD_W'(status);
  assign padMask   = PAD_W'(mask);
  assign padSens   = PAD_W'(sens);
  assign padPol    = PAD_W'(pol);
  assign bitBase   = {word, 5'b0};

  always_comb begin
    rdData = '0;
    if (wordOk) begin
      case (region)
        RGN_STATUS:   rdData = padStatus[bitBase +: BUS_DATA_W];
        RGN_MASK_SET: rdData = padMask[bitBase +: BUS_DATA_W];
        RGN_SENS_SET: rdData = padSens[bitBase +: BUS_DATA_W];
        RGN_POL_SET:  rdData = padPol[bitBase +: BUS_DATA_W];
        RGN_CTRL: begin
          if (word == '0) begin
            rdData[CTRL_EN_BIT]   = enableQ;
            rdData[CTRL_EDGE_BIT] = edgeOnlyQ;
          end
        end
        default: rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_rec_datapath.sv
module irq_rec_datapath
  import irq_rec_pkg::*;
#(
  parameter int NUM_LINES = 48
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  dpStrobe_t            strobe,
  output logic [NUM_LINES-1:0] status,
  output logic [NUM_LINES-1:0] mask,
  output logic [NUM_LINES-1:0] sens,
  output logic [NUM_LINES-1:0] pol,
  output logic [NUM_LINES-1:0] irqOut
);

  // Two-flop synchroniser plus one history stage for edge detection
  logic [NUM_LINES-1:0] syncA;
  logic [NUM_LINES-1:0] syncB;
  logic [NUM_LINES-1:0] prevB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= irqIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : gLine
    localparam int WORD = i / 32;
    localparam int BIT  = i % 32;

    logic hit;
    logic ackHit;
    logic replayHere;
    logic activeLvl;
    logic edgeSeen;
    logic lineEvt;
    logic statusQ;
    logic maskQ;
    logic sensQ;
    logic polQ;

    assign hit        = (strobe.word == WORD_IDX_W'(WORD)) && strobe.bits[BIT];
    assign ackHit     = hit && (strobe.op == OP_ACK);
    assign replayHere = strobe.replayBusy && (strobe.replayIdx == LINE_IDX_W'(i));

    assign activeLvl = polQ ? syncB[i] : ~syncB[i];
    assign edgeSeen  = polQ ? (syncB[i] & ~prevB[i]) : (~syncB[i] & prevB[i]);
    assign lineEvt   = sensQ ? (activeLvl & ~strobe.edgeOnly) : edgeSeen;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        statusQ <= 1'b0;
        maskQ   <= 1'b0;
        sensQ   <= 1'b0;
        polQ    <= 1'b0;
      end else begin
        if (hit && strobe.op == OP_MASK_SET)      maskQ <= 1'b1;
        else if (hit && strobe.op == OP_MASK_CLR) maskQ <= 1'b0;
        if (hit && strobe.op == OP_SENS_SET)      sensQ <= 1'b1;
        else if (hit && strobe.op == OP_SENS_CLR) sensQ <= 1'b0;
        if (hit && strobe.op == OP_POL_SET)       polQ  <= 1'b1;
        else if (hit && strobe.op == OP_POL_CLR)  polQ  <= 1'b0;
        // A new event outranks both acknowledge and replay clearing
        statusQ <= lineEvt | (statusQ & ~(ackHit | (replayHere & ~maskQ)));
      end
    end

    assign status[i] = statusQ;
    assign mask[i]   = maskQ;
    assign sens[i]   = sensQ;
    assign pol[i]    = polQ;

    assign irqOut[i] = strobe.replayBusy ? (replayHere & statusQ & ~maskQ)
                                         : (strobe.passEn & ~maskQ & activeLvl);
  end

endmodule

// File: rtl/irq_sleep_recorder.sv
module irq_sleep_recorder
  import irq_rec_pkg::*;
#(
  parameter int NUM_LINES = 48
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWrEn,
  input  logic [BUS_ADDR_W-1:0] busAddr,
  input  logic [BUS_DATA_W-1:0] busWrData,
  output logic [BUS_DATA_W-1:0] busRdData,
  input  logic [NUM_LINES-1:0]  irqIn,
  output logic [NUM_LINES-1:0]  irqOut
);

  dpStrobe_t            dpStrobe;
  logic [NUM_LINES-1:0] statusVec;
  logic [NUM_LINES-1:0] maskVec;
  logic [NUM_LINES-1:0] sensVec;
  logic [NUM_LINES-1:0] polVec;
  logic                 replayBusy;
  logic                 sleepEn;

  assign replayBusy = dpStrobe.replayBusy;
  assign sleepEn    = !dpStrobe.passEn;

  irq_rec_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (busWrEn),
    .addr   (busAddr),
    .wrData (busWrData),
    .status (statusVec),
    .mask   (maskVec),
    .sens   (sensVec),
    .pol    (polVec),
    .rdData (busRdData),
    .strobe (dpStrobe)
  );

  irq_rec_datapath #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .irqIn  (irqIn),
    .strobe (dpStrobe),
    .status (statusVec),
    .mask   (maskVec),
    .sens   (sensVec),
    .pol    (polVec),
    .irqOut (irqOut)
  );

endmodule

// File: rtl/irq_sleep_recorder_chk.sv
module irq_sleep_recorder_chk #(
  parameter int NUM_LINES = 48
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic                 busy,
  input logic                 sleepEn,
  input logic [NUM_LINES-1:0] status,
  input logic [NUM_LINES-1:0] mask,
  input logic [NUM_LINES-1:0] irqOut
);

  // R9: a replay scan drives at most one line at a time
  assert_replay_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> $onehot0(irqOut));

  // R10: masked lines stay silent toward the parent
  assert_masked_silent_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut & mask) == '0);

  // R8: sleep mode with no scan keeps the parent side quiet
  assert_sleep_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sleepEn && !busy) |-> (irqOut == '0));

  // R5: without a bus write or a scan, recorded bits never drop
  assert_status_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !busy) |=> ((status & $past(status)) == $past(status)));

endmodule

bind irq_sleep_recorder irq_sleep_recorder_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (busWrEn),
  .busy    (replayBusy),
  .sleepEn (sleepEn),
  .status  (statusVec),
  .mask    (maskVec),
  .irqOut  (irqOut)
);

// File: tb/irq_sleep_recorder_tb.sv
module irq_sleep_recorder_tb;

  localparam int N = 36;
  localparam logic [11:0] A_STATUS = 12'h000;
  localparam logic [11:0] A_ACK    = 12'h040;
  localparam logic [11:0] A_MSET   = 12'h0C0;
  localparam logic [11:0] A_MCLR   = 12'h100;
  localparam logic [11:0] A_SSET   = 12'h180;
  localparam logic [11:0] A_SCLR   = 12'h1C0;
  localparam logic [11:0] A_PSET   = 12'h240;
  localparam logic [11:0] A_PCLR   = 12'h280;
  localparam logic [11:0] A_CTRL   = 12'h300;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busWrEn = 1'b0;
  logic [11:0]  busAddr = '0;
  logic [31:0]  busWrData = '0;
  logic [31:0]  busRdData;
  logic [N-1:0] irqIn = '0;
  logic [N-1:0] irqOut;

  int testsRun = 0;
  int testsFailed = 0;

  always #5 clk = ~clk;

  irq_sleep_recorder #(.NUM_LINES(N)) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .irqIn     (irqIn),
    .irqOut    (irqOut)
  );

  task automatic checkVal(string tag, logic [63:0] act, logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic writeLines(logic [11:0] base, logic [N-1:0] v);
    busWrite(base, v[31:0]);
    busWrite(base + 12'h4, 32'(v[N-1:32]));
  endtask

  task automatic readLines(logic [11:0] base, output logic [N-1:0] v);
    logic [31:0] w0;
    logic [31:0] w1;
    busRead(base, w0);
    busRead(base + 12'h4, w1);
    v = {w1[N-33:0], w0};
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    #1_000_000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog R9: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [N-1:0] riseV, fallV, hiV, loV, polV, sensV, passM, replM, rec, v, expP;
    logic [31:0]  w;
    logic [11:0]  setB [3];
    logic [11:0]  clrB [3];

    setB[0] = A_MSET; setB[1] = A_SSET; setB[2] = A_PSET;
    clrB[0] = A_MCLR; clrB[1] = A_SCLR; clrB[2] = A_PCLR;
    riseV = '0; fallV = '0; hiV = '0; loV = '0; passM = '0; replM = '0;
    for (int i = 0; i < N; i++) begin
      case (i % 4)
        0: riseV[i] = 1'b1;
        1: fallV[i] = 1'b1;
        2: hiV[i]   = 1'b1;
        default: loV[i] = 1'b1;
      endcase
      passM[i] = (i % 3) == 0;
      replM[i] = (i % 5) == 2;
    end
    polV  = riseV | hiV;
    sensV = hiV | loV;

    waitCycles(3);
    rstN = 1'b1;

    // R7: reset values
    readLines(A_STATUS, v); checkVal("R7 reset status", 64'(v), 64'(0));
    readLines(A_MSET, v);   checkVal("R7 reset mask", 64'(v), 64'(0));
    readLines(A_SSET, v);   checkVal("R7 reset sens", 64'(v), 64'(0));
    readLines(A_PSET, v);   checkVal("R7 reset pol", 64'(v), 64'(0));
    busRead(A_CTRL, w);     checkVal("R7 reset ctrl", 64'(w), 64'(0));
    // R8: polarity 0 with idle-low inputs is active
    checkVal("R8 reset passthrough", 64'(irqOut), 64'({N{1'b1}}));

    // R1, R2: walk every line through every set/clear pair
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < N; i++) begin
        busWrite(setB[k] + 12'(4 * (i / 32)), 32'(1) << (i % 32));
        busRead(setB[k] + 12'(4 * (i / 32)), w);
        checkVal("R1 set word/bit", 64'(w), 64'(32'(1) << (i % 32)));
        busWrite(clrB[k] + 12'(4 * (i / 32)), 32'(1) << (i % 32));
        readLines(setB[k], v);
        checkVal("R2 clear restores zero", 64'(v), 64'(0));
      end
    end
    writeLines(A_MSET, '1);
    busWrite(A_MCLR, 32'hAAAA_AAAA);
    readLines(A_MSET, v);
    checkVal("R2 zero bits untouched", 64'(v), 64'({4'hF, 32'h5555_5555}));
    busRead(A_MCLR, w); checkVal("R2 clear reads zero", 64'(w), 64'(0));
    busRead(A_ACK, w);  checkVal("R2 ack reads zero", 64'(w), 64'(0));
    writeLines(A_MCLR, '1);

    // R3, R5: type decode sweep
    writeLines(A_PSET, polV);
    writeLines(A_SSET, sensV);
    waitCycles(4);
    writeLines(A_ACK, '1);
    readLines(A_STATUS, v);
    checkVal("R5 ack loses to live low level", 64'(v), 64'(loV));
    irqIn = '1;
    waitCycles(5);
    readLines(A_STATUS, v);
    checkVal("R3 rise/high recorded", 64'(v), 64'(loV | riseV | hiV));
    checkVal("R8 passthrough high inputs", 64'(irqOut), 64'(polV));
    writeLines(A_ACK, '1);
    readLines(A_STATUS, v);
    checkVal("R5 ack loses to live high level", 64'(v), 64'(hiV));
    irqIn = '0;
    waitCycles(5);
    readLines(A_STATUS, v);
    checkVal("R3 fall/low recorded", 64'(v), 64'(hiV | fallV | loV));
    checkVal("R8 passthrough low inputs", 64'(irqOut), 64'(fallV | loV));
    writeLines(A_MSET, passM);
    checkVal("R10 mask blocks passthrough", 64'(irqOut), 64'(~passM & (fallV | loV)));
    writeLines(A_MCLR, passM);
    writeLines(A_ACK, fallV);
    readLines(A_STATUS, v);
    checkVal("R5 partial ack", 64'(v), 64'(hiV | loV));

    // R4, R6: enabled, edge-only recording
    busWrite(A_CTRL, 32'h3);
    busRead(A_CTRL, w); checkVal("R7 ctrl readback", 64'(w), 64'(3));
    writeLines(A_ACK, '1);
    readLines(A_STATUS, v);
    checkVal("R6 level lines not recorded", 64'(v), 64'(0));
    checkVal("R8 enable silences output", 64'(irqOut), 64'(0));
    irqIn = '1;
    waitCycles(5);
    readLines(A_STATUS, v);
    checkVal("R4 recorded while enabled", 64'(v), 64'(riseV));
    irqIn = '0;
    waitCycles(5);
    readLines(A_STATUS, v);
    checkVal("R6 only edge lines recorded", 64'(v), 64'(riseV | fallV));
    rec = riseV | fallV;

    // R9, R10: replay with some lines masked
    writeLines(A_MSET, replM);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = A_CTRL; busWrData = 32'h7;
    @(negedge clk);
    busWrEn = 1'b0;
    for (int k = 0; k < N; k++) begin
      expP = (rec[k] && !replM[k]) ? (N'(1) << k) : '0;
      checkVal("R9 replay pulse", 64'(irqOut), 64'(expP));
      @(negedge clk);
    end
    readLines(A_STATUS, v);
    checkVal("R10 masked lines survive replay", 64'(v), 64'(rec & replM));
    busRead(A_CTRL, w); checkVal("R7 flush reads zero", 64'(w), 64'(3));
    checkVal("R8 quiet after replay", 64'(irqOut), 64'(0));

    // R9: second replay, level lines re-recording, pass-through suspended
    writeLines(A_MCLR, '1);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = A_CTRL; busWrData = 32'h4;
    @(negedge clk);
    busWrEn = 1'b0;
    for (int k = 0; k < N; k++) begin
      expP = (((rec & replM) | loV) >> k) & N'(1) ? (N'(1) << k) : '0;
      checkVal("R9 replay with live levels", 64'(irqOut), 64'(expP));
      @(negedge clk);
    end
    readLines(A_STATUS, v);
    checkVal("R9 status after replay", 64'(v), 64'(loV));
    checkVal("R8 passthrough resumes", 64'(irqOut), 64'(fallV | loV));

    finishRun();
  end

endmodule